// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a system-on-chip. Software reaches it through a simple 32-bit register port with a select, a write strobe, a byte address, write data and combinational read data. It holds three registers: a restart (kick) register, an action register and a mode register. When the watchdog is armed, it counts down a timeout in half-second ticks. If software fails to restart it in time, the countdown expires. If the system-reset action is selected at that moment, the block raises a reset request for a fixed number of clocks.

Two things make software mistakes unlikely to change the watchdog. A restart happens only when a fixed 13-bit pattern is written to the kick register. A change to the action or mode register happens only when the upper half-word of the write data carries a 16-bit key. The timeout is not a raw count: it is a 4-bit code looked up in a non-linear table that runs from half a second to sixteen seconds. A parameter sets how many input clocks make one half-second tick.

Top module: `keyed_wdog`

## Requirements
- R1: After the asynchronous active-low reset, the block has action 00, mode enable 0, mode code 0 and `sys_rst_out` low. Asserting reset clears `sys_rst_out` at once, even in the middle of a pulse.
- R2: A write to the action register (offset 0x14) or the mode register (offset 0x18) changes that register only when write-data bits [31:16] equal 0x16AA. Any other write leaves the register unchanged.
- R3: Read data is laid out as follows. The action register returns its value in bits [1:0]. The mode register returns the enable in bit 0 and the code in bits [7:4]. All other bits read zero, including the key bits [31:16]. The kick register (offset 0x10) reads zero.
- R4: Each timeout code selects a number of half-second ticks: code 0 gives 1; codes 1 to 6 give twice the code; code 7 gives 16, 8 gives 20, 9 gives 24, 0xA gives 28 and 0xB gives 32. Let P be clocks per tick and L the tick count. If a keyed mode write arms the watchdog at edge E, the first cycle with `sys_rst_out` high follows edge E+1+L·P.
- R5: Codes 0xC to 0xF select 32 ticks, the same as code 0xB.
- R6: A write to the kick register whose bits [12:0] equal 0x14AF restarts the countdown one cycle after the write edge. Any other kick write has no effect on the timing of expiry.
- R7: A keyed mode write that changes the code or the enable restarts the countdown from the new code's full length.
- R8: While the enable is 0, the countdown does not run and no expiry occurs.
- R9: An expiry raises `sys_rst_out` only when the action field is 01. With any other action value, expiry produces no output.
- R10: Each expiry with action 01 drives `sys_rst_out` from a register, high for exactly RST_CYCLES consecutive clocks.
- R11: After an expiry, the countdown reloads and runs again, so the next expiry comes L·P clocks later unless software restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sys_rst_out | output | 1 | Registered system-reset request |

## Verification
The pulse-width property assumes that RST_CYCLES is smaller than the shortest expiry period P. Under that assumption, a new expiry can never extend a pulse that is still running. The bench uses P = 4 and RST_CYCLES = 3 to respect it. The register-hold properties take the bus to be a one-cycle strobe with stable address and data. The bench drives each access at a falling edge and holds it for exactly one rising edge. Expiry timing is measured from the write edge, the same way for arming, kicking, bad kicks and code changes. Before each new case, the bench disarms the watchdog and lets any pulse finish.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam logic [7:0]  OFS_KICK   = 8'h10;
  localparam logic [7:0]  OFS_ACTION = 8'h14;
  localparam logic [7:0]  OFS_MODE   = 8'h18;
  localparam logic [15:0] WR_KEY     = 16'h16AA;
  localparam logic [12:0] KICK_WORD  = 13'h14AF;
  localparam logic [1:0]  ACT_SYSRST = 2'b01;
  localparam int          TICK_W     = 6;

  typedef struct packed {
    logic [1:0] act;
    logic       en;
    logic [3:0] code;
  } kwd_cfg_t;

  // half-second ticks per timeout code
  function automatic logic [TICK_W-1:0] half_ticks(input logic [3:0] code);
    logic [TICK_W-1:0] n;
    if (code == 4'd0)       n = TICK_W'(1);
    else if (code <= 4'd6)  n = TICK_W'({code, 1'b0});
    else if (code <= 4'd11) n = TICK_W'(16 + 4 * (int'(code) - 7));
    else                    n = TICK_W'(32);
    return n;
  endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs #(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output kwd_pkg::kwd_cfg_t   cfg_q,
  output logic                reload_q
);
  import kwd_pkg::*;

  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(OFS_ACTION);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

  kwd_cfg_t cfg_d;
  logic     reload_d;
  logic     key_ok, kick_hit, act_hit, mode_hit;
  logic     unused_wbits;

  assign unused_wbits = ^bus_wdata[15:13];

  always_comb begin
    key_ok   = (bus_wdata[31:16] == WR_KEY);
    kick_hit = bus_sel && bus_we && (bus_addr == A_KICK) && (bus_wdata[12:0] == KICK_WORD);
    act_hit  = bus_sel && bus_we && (bus_addr == A_ACT)  && key_ok;
    mode_hit = bus_sel && bus_we && (bus_addr == A_MODE) && key_ok;

    cfg_d = cfg_q;
    if (act_hit) cfg_d.act = bus_wdata[1:0];
    if (mode_hit) begin
      cfg_d.en   = bus_wdata[0];
      cfg_d.code = bus_wdata[7:4];
    end
    reload_d = kick_hit ||
               (mode_hit && ((bus_wdata[0] != cfg_q.en) || (bus_wdata[7:4] != cfg_q.code)));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ACT) begin
      bus_rdata[1:0] = cfg_q.act;
    end else if (bus_addr == A_MODE) begin
      bus_rdata[0]   = cfg_q.en;
      bus_rdata[7:4] = cfg_q.code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      reload_q <= reload_d;
    end
  end

endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int HALF_TICK_CLKS = 12_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF_TICK_CLKS > 2) ? $clog2(HALF_TICK_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICK_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = !clr && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic [3:0] code,
  output logic       expire
);
  import kwd_pkg::*;

  logic [TICK_W-1:0] rem_q, rem_d, full;

  always_comb begin
    full   = half_ticks(code);
    expire = tick && !clr && (rem_q == TICK_W'(1));
    rem_d  = rem_q;
    if (clr || expire) rem_d = full;
    else if (tick)     rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= TICK_W'(1);
    else        rem_q <= rem_d;
  end

endmodule

// File: rtl/kwd_rstgen.sv
module kwd_rstgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_d;

  always_comb begin
    out_d = 1'b0;
    cnt_d = '0;
    if (fire) begin
      out_d = 1'b1;
      cnt_d = CW'(RST_CYCLES - 1);
    end else if (cnt_q != '0) begin
      out_d = 1'b1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rst_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rst_out <= out_d;
    end
  end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int ADDR_W         = 8,
  parameter int HALF_TICK_CLKS = 12_000_000,
  parameter int RST_CYCLES     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_out
);
  import kwd_pkg::*;

  kwd_cfg_t cfg_q;
  logic     reload_q, clr, tick, expire, fire;

  kwd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_q(cfg_q), .reload_q(reload_q)
  );

  assign clr  = reload_q || !cfg_q.en;
  assign fire = expire && (cfg_q.act == ACT_SYSRST);

  kwd_prescale #(.HALF_TICK_CLKS(HALF_TICK_CLKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
  );

  kwd_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
    .code(cfg_q.code), .expire(expire)
  );

  kwd_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rst_out(sys_rst_out)
  );

endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
  parameter int ADDR_W     = 8,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input kwd_pkg::kwd_cfg_t cfg_q,
  input logic              sys_rst_out
);
  import kwd_pkg::*;

  logic keyed_act, keyed_mode;
  int   hi_cnt;

  assign keyed_act  = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_ACTION)) && (bus_wdata[31:16] == WR_KEY);
  assign keyed_mode = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_MODE))   && (bus_wdata[31:16] == WR_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= 0;
    else if (sys_rst_out) hi_cnt <= hi_cnt + 1;
    else                  hi_cnt <= 0;
  end

  // R2
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !keyed_act |=> $stable(cfg_q.act));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !keyed_mode |=> ($stable(cfg_q.en) && $stable(cfg_q.code)));

  // R9
  rst_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_out) |-> ($past(cfg_q.act) == ACT_SYSRST));

  // R8
  rst_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_out) |-> $past(cfg_q.en));

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_out) |-> (hi_cnt == RST_CYCLES));

endmodule

bind keyed_wdog kwd_chk #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_q(cfg_q),
  .sys_rst_out(sys_rst_out)
);

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;

  localparam int P    = 4;
  localparam int RSTN = 3;
  localparam int VN   = 10;
  localparam logic [3:0] VCODE [VN] = '{4'h0, 4'h1, 4'h3, 4'h6, 4'h7, 4'h8, 4'hA, 4'hB, 4'hC, 4'hF};
  localparam int         VHT   [VN] = '{1, 2, 6, 12, 16, 20, 28, 32, 32, 32};

  logic        clk, rst_n, bus_sel, bus_we, sys_rst_out;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  keyed_wdog #(.ADDR_W(8), .HALF_TICK_CLKS(P), .RST_CYCLES(RSTN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_out(sys_rst_out)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; the access spans exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wait_rise(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sys_rst_out && n < lim);
  endtask

  task automatic high_len(output int n);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sys_rst_out) n++;
      else break;
    end
  endtask

  task automatic disarm(input logic [3:0] code);
    wr(8'h18, {16'h16AA, 8'h00, code, 4'h0});
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, w, m;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk(sys_rst_out == 0, "R1 rst_out", sys_rst_out, 0);
    rd(8'h14, d); chk(d == 0, "R1 action", d, 0);
    rd(8'h18, d); chk(d == 0, "R1 mode", d, 0);
    rst_n = 1;
    @(negedge clk);

    // key checks and read layout
    wr(8'h18, 32'h0000_0051);
    rd(8'h18, d); chk(d == 0, "R2 unkeyed mode", d, 0);
    wr(8'h18, 32'h16AA_0050);
    rd(8'h18, d); chk(d == 32'h50, "R3 mode readback", d, 32'h50);
    rd(8'h10, d); chk(d == 0, "R3 kick reads zero", d, 0);
    wr(8'h14, 32'h0000_0001);
    rd(8'h14, d); chk(d == 0, "R2 unkeyed action", d, 0);
    wr(8'h14, 32'h16AA_FFFD);
    rd(8'h14, d); chk(d == 1, "R3 action readback", d, 1);
    wr(8'h14, 32'h16A0_0002);
    rd(8'h14, d); chk(d == 1, "R2 bad key action", d, 1);

    // vector table: code -> expiry time, pulse width, repeat period
    for (int v = 0; v < VN; v++) begin
      wr(8'h18, {16'h16AA, 8'h00, VCODE[v], 4'h1});
      wait_rise(400, n);
      chk(n == 1 + VHT[v] * P, (VCODE[v] >= 4'hC) ? "R5 timeout" : "R4 timeout", n, 1 + VHT[v] * P);
      high_len(w);
      chk(w == RSTN, "R10 pulse width", w, RSTN);
      wait_rise(400, m);
      chk(w + m == VHT[v] * P, "R11 repeat period", w + m, VHT[v] * P);
      disarm(VCODE[v]);
    end

    // R6 good kick restarts
    wr(8'h18, 32'h16AA_0011);
    repeat (4) @(negedge clk);
    wr(8'h10, 32'h0000_14AF);
    wait_rise(100, n);
    chk(n == 9, "R6 kick restart", n, 9);
    disarm(4'h1);

    // R6 bad kicks ignored
    wr(8'h18, 32'h16AA_0011);
    wr(8'h10, 32'h0000_14AE);
    wr(8'h10, 32'h0000_14B1);
    wait_rise(100, n);
    chk(n == 7, "R6 bad kick ignored", n, 7);
    disarm(4'h1);

    // R7 code change reloads
    wr(8'h18, 32'h16AA_0011);
    wr(8'h18, 32'h16AA_0001);
    wait_rise(100, n);
    chk(n == 5, "R7 code change reload", n, 5);
    disarm(4'h0);

    // R8 disable stops
    wr(8'h18, 32'h16AA_0001);
    wr(8'h18, 32'h16AA_0000);
    wait_rise(40, n);
    chk(sys_rst_out == 0, "R8 disabled no expiry", sys_rst_out, 0);

    // R9 other actions give no output
    for (int a = 0; a < 4; a++) begin
      if (a == 1) continue;
      wr(8'h14, 32'h16AA_0000 | a);
      wr(8'h18, 32'h16AA_0001);
      wait_rise(40, n);
      chk(sys_rst_out == 0, "R9 action not 01", sys_rst_out, 0);
      disarm(4'h0);
    end

    // R1 async reset mid-pulse
    wr(8'h14, 32'h16AA_0001);
    wr(8'h18, 32'h16AA_0001);
    wait_rise(100, n);
    chk(sys_rst_out == 1, "R1 pulse before reset", sys_rst_out, 1);
    rst_n = 0;
    #1;
    chk(sys_rst_out == 0, "R1 async clear", sys_rst_out, 0);
    rd(8'h14, d); chk(d == 0, "R1 action cleared", d, 0);
    rd(8'h18, d); chk(d == 0, "R1 mode cleared", d, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule